// File: doc/BRIEF.md
# I2C Master SCL Timing Engine

This block generates the serial clock of an I2C master and sequences the STOP condition. Both bus lines are treated as open-drain: the block only ever requests that a line be pulled low, and an external pull-up brings a released line high. A down-counter loaded from a 7-bit reload value times each phase of the clock. Every count step is one machine cycle, which `tick_i` marks with a single-clock pulse. A slave may hold SCL low after the master has released it. While that lasts, the counter stands still. It restarts from the reload value only once SCL is sampled high, so a stretched clock still gets a full high phase.

`byte_go_i` starts one byte, which is nine SCL pulses. After the ninth pulse the engine holds SCL low and waits. From this hold point it accepts either another byte or a STOP request. A STOP pulls SDA low, releases SCL, waits for SCL high plus one reload interval, and then releases SDA. When SDA is seen high one interval later, the engine raises a sticky STOP-detected flag and pulses an interrupt. SCL and SDA arrive already synchronised to `clk_i`. The reload value must stay stable while `busy_o` is high. Byte data, START, acknowledge and addressing are handled elsewhere.

Top module: `i2c_scl_engine`

## Requirements
- R1: While `rst_ni` is low, both pull enables are 0 and `busy_o`, `stop_det_o` and `irq_o` are 0. This holds even in the middle of a byte. After reset the engine is idle with both lines released.
- R2: `byte_go_i` seen on a tick while idle or at the hold point produces exactly 9 rising edges on SCL. The engine then holds SCL pulled low with SDA released and `busy_o` at 0. Accepting the byte clears `stop_det_o`.
- R3: Each master low phase inside a byte keeps `scl_pull_o` at 1 for reload+1 ticks (4*(reload+1) clocks when a tick comes every 4 clocks).
- R4: While SCL is released but held low externally, the counter does not advance. The high phase, measured from the line rising until the master pulls it low again, lasts at least reload+1 ticks and at most reload+2 ticks.
- R5: A reload value of 0 times every phase as if it were 1.
- R6: `stop_req_i` seen on a tick at the hold point pulls SDA low while SCL is still low. SCL is released reload+1 ticks later, and SDA is low when SCL rises.
- R7: During a STOP, SDA is released reload+1 ticks after SCL is sampled high, and SCL is high when SDA rises.
- R8: The STOP completes one reload interval after SDA release, once SDA is sampled high. At that point `stop_det_o` goes to 1 and stays there until the next accepted byte, and `irq_o` pulses for exactly one clock. `busy_o` returns to 0 and both lines are released.
- R9: A `stop_req_i` while a byte's clocks are running is ignored. SDA is never pulled, no flag is raised, and the byte still completes its 9 pulses.
- R10: A `stop_req_i` while idle is ignored. Lines stay released, `busy_o` stays 0, and `stop_det_o` and `irq_o` are unchanged.
- R11: With `tick_i` held at 0, the pull enables and `busy_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 7 | Counter reload value for each clock phase |
| byte_go_i | input | 1 | Request nine SCL pulses |
| stop_req_i | input | 1 | Request a STOP condition |
| tick_i | input | 1 | One-clock pulse per machine cycle |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| stop_det_o | output | 1 | STOP completed, sticky until next byte |
| irq_o | output | 1 | One-clock pulse when a STOP completes |
| busy_o | output | 1 | Clocks or STOP sequence in progress |

## Verification
The hardest case to reach is a slave releasing SCL at an arbitrary clock within a machine cycle. Only that case shows whether the high phase is timed from the observed rise and not from the master's own release. A slave model in the bench starts a random hold of 0 to 40 clocks on every master pull. Many holds therefore outlast the low phase and end at every phase offset against the tick. Every high phase is measured against a two-sided window. Mid-byte STOP requests and paused ticks are driven at chosen points inside a running byte, because the wrong-time request paths cannot be reached from the idle bus.

// File: rtl/scl_eng_pkg.sv
`timescale 1ns/1ps
package scl_eng_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOW,
    ST_REL,
    ST_HIGH,
    ST_HOLD,
    ST_SP_PREP,
    ST_SP_REL,
    ST_SP_SETUP,
    ST_SP_SDA
  } eng_state_e;
endpackage

// File: rtl/scl_brg.sv
`timescale 1ns/1ps
module scl_brg #(
  parameter int RW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          count_i,
  input  logic [RW-1:0] reload_i,
  output logic          zero_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] start_val;

  // zero reload behaves as one
  assign start_val = (reload_i == '0) ? RW'(1) : reload_i;
  assign zero_o    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= start_val;
    else if (count_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // R5
  nonzero_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q != '0);
endmodule

// File: rtl/scl_seq.sv
`timescale 1ns/1ps
module scl_seq import scl_eng_pkg::*; #(
  parameter int RW   = 7,
  parameter int BITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          go_i,
  input  logic          stop_req_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          zero_i,
  input  logic [RW-1:0] reload_i,
  output logic          load_o,
  output logic          count_o,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          stop_det_o,
  output logic          irq_o,
  output logic          busy_o
);
  localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BITS - 1);

  eng_state_e     state_q;
  logic [BCW-1:0] bit_q;
  logic           scl_pull_q, sda_pull_q, det_q, irq_q;
  logic           timed, roll;

  always_comb begin
    timed   = state_q inside {ST_LOW, ST_HIGH, ST_SP_PREP, ST_SP_SETUP, ST_SP_SDA};
    count_o = tick_i && timed;
    roll    = count_o && zero_i;
    load_o  = (tick_i && ((state_q == ST_IDLE && go_i) ||
                          (state_q == ST_HOLD && (stop_req_i || go_i)) ||
                          ((state_q == ST_REL || state_q == ST_SP_REL) && scl_i))) ||
              (roll && (state_q == ST_HIGH || state_q == ST_SP_SETUP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
      det_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: if (go_i) begin
            state_q    <= ST_LOW;
            scl_pull_q <= 1'b1;
            bit_q      <= '0;
            det_q      <= 1'b0;
          end
          ST_LOW: if (roll) begin
            scl_pull_q <= 1'b0;
            state_q    <= ST_REL;
          end
          // counter frozen until the line is really high
          ST_REL: if (scl_i) state_q <= ST_HIGH;
          ST_HIGH: if (roll) begin
            scl_pull_q <= 1'b1;
            if (bit_q == LAST_BIT) state_q <= ST_HOLD;
            else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= ST_LOW;
            end
          end
          ST_HOLD: if (stop_req_i) begin
            state_q    <= ST_SP_PREP;
            sda_pull_q <= 1'b1;
          end else if (go_i) begin
            state_q <= ST_LOW;
            bit_q   <= '0;
            det_q   <= 1'b0;
          end
          ST_SP_PREP: if (roll) begin
            scl_pull_q <= 1'b0;
            state_q    <= ST_SP_REL;
          end
          ST_SP_REL: if (scl_i) state_q <= ST_SP_SETUP;
          ST_SP_SETUP: if (roll) begin
            sda_pull_q <= 1'b0;
            state_q    <= ST_SP_SDA;
          end
          ST_SP_SDA: if (roll && sda_i) begin
            det_q   <= 1'b1;
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign stop_det_o = det_q;
  assign irq_o      = irq_q;
  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_HOLD);

  // checker: ticks spent in the high phase, independent of the counter
  logic [RW:0]   hi_ticks_q;
  logic [RW-1:0] eff_chk;
  assign eff_chk = (reload_i == '0) ? RW'(1) : reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              hi_ticks_q <= '0;
    else if (load_o)                                          hi_ticks_q <= '0;
    else if (count_o && state_q == ST_HIGH && ~&hi_ticks_q)   hi_ticks_q <= hi_ticks_q + 1'b1;
  end

  // R4
  high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && count_o && zero_i) |-> hi_ticks_q >= {1'b0, eff_chk});
  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !scl_pull_q && !sda_pull_q);
  // R9
  no_sda_in_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_LOW, ST_REL, ST_HIGH} |-> !sda_pull_q);
  // R7
  sda_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_q) |-> !scl_pull_q);
  // R8
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> det_q && !scl_pull_q && !sda_pull_q);
  // R10
  idle_stop_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && stop_req_i && !go_i) |=> state_q == ST_IDLE);
  // R11
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q) && $stable(scl_pull_q));
endmodule

// File: rtl/i2c_scl_engine.sv
`timescale 1ns/1ps
module i2c_scl_engine #(
  parameter int RW   = 7,
  parameter int BITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] reload_i,
  input  logic          byte_go_i,
  input  logic          stop_req_i,
  input  logic          tick_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          stop_det_o,
  output logic          irq_o,
  output logic          busy_o
);
  logic brg_load, brg_count, brg_zero;

  scl_brg #(.RW(RW)) i_brg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (brg_load),
    .count_i  (brg_count),
    .reload_i (reload_i),
    .zero_o   (brg_zero)
  );

  scl_seq #(.RW(RW), .BITS(BITS)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .go_i       (byte_go_i),
    .stop_req_i (stop_req_i),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .zero_i     (brg_zero),
    .reload_i   (reload_i),
    .load_o     (brg_load),
    .count_o    (brg_count),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .stop_det_o (stop_det_o),
    .irq_o      (irq_o),
    .busy_o     (busy_o)
  );
endmodule

// File: tb/test_i2c_scl_engine.sv
`timescale 1ns/1ps
module test_i2c_scl_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] reload = 7'd5;
  logic       byte_go = 1'b0, stop_req = 1'b0, tick = 1'b0, tick_en = 1'b1;
  logic       scl_pull, sda_pull, stop_det, irq, busy;
  logic       slave_hold = 1'b0, stretch_en = 1'b0, prev_pull = 1'b0;
  logic       scl_line, sda_line;
  int         phase = 0, hold_left = 0;
  int         n_chk = 0, n_fail = 0;
  int         cur_eff = 5, rises = 0, irq_seen = 0;
  int         lo_len = 0, hi_len = 0;
  bit         lo_taint = 1'b1, hi_taint = 1'b1, scl_prev = 1'b1, sda_prev = 1'b1;
  bit         in_stop = 1'b0, len_skip = 1'b0, sda_seen = 1'b0, cur_zero = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus with pull-ups
  assign scl_line = !(scl_pull || slave_hold);
  assign sda_line = !sda_pull;

  i2c_scl_engine i_i2c_scl_engine (
    .clk_i (clk), .rst_ni (rst_n), .reload_i (reload), .byte_go_i (byte_go),
    .stop_req_i (stop_req), .tick_i (tick), .scl_i (scl_line), .sda_i (sda_line),
    .scl_pull_o (scl_pull), .sda_pull_o (sda_pull), .stop_det_o (stop_det),
    .irq_o (irq), .busy_o (busy)
  );

  function automatic int eff_of(int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // machine-cycle tick every 4 clocks
  always @(negedge clk) begin
    phase <= (phase == 3) ? 0 : phase + 1;
    tick  <= tick_en && (phase == 3);
  end

  // slave: random hold of SCL after each master pull-down
  always @(negedge clk) begin
    prev_pull <= scl_pull;
    if (!rst_n) begin
      hold_left  <= 0;
      slave_hold <= 1'b0;
    end else if (stretch_en && scl_pull && !prev_pull) begin
      hold_left  <= $urandom_range(0, 40);
      slave_hold <= 1'b1;
    end else if (hold_left > 0) hold_left <= hold_left - 1;
    else slave_hold <= 1'b0;
  end

  // line monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      lo_len = 0; hi_len = 0; lo_taint = 1'b1; hi_taint = 1'b1;
      scl_prev = scl_line; sda_prev = sda_line;
    end else begin
      if (irq) irq_seen++;
      if (sda_pull) sda_seen = 1'b1;
      if (scl_pull) begin
        lo_len++;
        if (!busy) lo_taint = 1'b1;
      end else if (lo_len > 0) begin
        if (!lo_taint && !len_skip)
          chk(lo_len == 4*(cur_eff+1), cur_zero ? "R5 low phase" : "R3 low phase",
              lo_len, 4*(cur_eff+1));
        lo_len = 0; lo_taint = 1'b0;
      end
      if (scl_line) begin
        if (!scl_prev) begin
          rises++; hi_len = 0; hi_taint = 1'b0;
          if (in_stop) chk(!sda_line, "R6 sda low at scl rise", sda_line, 0);
        end
        hi_len++;
        if (!busy) hi_taint = 1'b1;
      end else if (scl_prev && !hi_taint && !len_skip) begin
        chk(hi_len >= 4*(cur_eff+1) && hi_len <= 4*(cur_eff+2), "R4 high phase",
            hi_len, 4*(cur_eff+1));
      end
      if (in_stop && sda_line && !sda_prev) begin
        chk(scl_line, "R7 scl high at sda rise", scl_line, 1);
        chk(hi_len >= 4*(cur_eff+1), "R7 sda setup", hi_len, 4*(cur_eff+1));
      end
      scl_prev = scl_line; sda_prev = sda_line;
    end
  end

  task automatic set_reload(input int r);
    reload = 7'(r); cur_eff = eff_of(r); cur_zero = (r == 0);
  endtask

  task automatic launch(input int r, input bit st);
    set_reload(r); stretch_en = st; len_skip = 1'b0; rises = 0;
    byte_go = 1'b1;
    do @(negedge clk); while (!busy);
    byte_go = 1'b0;
  endtask

  task automatic finish_byte(input string tag);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(rises == 9, tag, rises, 9);
    chk(scl_pull && !sda_pull, "R2 hold state", {scl_pull, sda_pull}, 2);
    chk(!stop_det, "R2 stop_det cleared", stop_det, 0);
  endtask

  task automatic run_byte(input int r, input bit st);
    launch(r, st);
    finish_byte("R2 nine pulses");
  endtask

  task automatic do_stop();
    int i0;
    i0 = irq_seen; in_stop = 1'b1; stretch_en = 1'b0;
    stop_req = 1'b1;
    do @(negedge clk); while (!busy);
    stop_req = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(stop_det, "R8 stop_det set", stop_det, 1);
    chk(irq_seen == i0 + 1, "R8 irq one pulse", irq_seen - i0, 1);
    chk(!scl_pull && !sda_pull && scl_line && sda_line, "R8 lines released",
        {scl_pull, sda_pull}, 0);
    in_stop = 1'b0;
  endtask

  task automatic idle_stop();
    int  i0;
    bit  d0;
    i0 = irq_seen; d0 = stop_det; sda_seen = 1'b0;
    stop_req = 1'b1;
    repeat (24) @(negedge clk);
    chk(!busy && !scl_pull && !sda_seen, "R10 idle stop ignored", busy, 0);
    chk(irq_seen == i0 && stop_det == d0, "R10 flags unchanged", stop_det, d0);
    stop_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy && !stop_det && !irq, "R1 in reset",
        {scl_pull, sda_pull, busy, stop_det, irq}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy, "R1 idle after reset", {scl_pull, sda_pull, busy}, 0);

    idle_stop();                 // R10 with flag clear
    run_byte(5, 1'b0);           // R2 R3 R4
    run_byte(0, 1'b0);           // R5
    run_byte(2, 1'b1);           // R4 stretched
    do_stop();                   // R6 R7 R8
    idle_stop();                 // R10 with flag set

    // R9: stop request while clocks run
    sda_seen = 1'b0;
    begin
      int i0;
      i0 = irq_seen;
      launch(4, 1'b0);
      repeat (20) @(negedge clk);
      stop_req = 1'b1;
      repeat (12) @(negedge clk);
      stop_req = 1'b0;
      finish_byte("R9 byte completes");
      chk(!sda_seen, "R9 sda never pulled", sda_seen, 0);
      chk(irq_seen == i0, "R9 no irq", irq_seen - i0, 0);
    end

    // R11: ticks paused mid-byte
    begin
      bit sp, dp, bz, moved;
      launch(4, 1'b0);
      repeat (30) @(negedge clk);
      len_skip = 1'b1;
      @(posedge clk); tick_en = 1'b0;
      repeat (2) @(negedge clk);
      sp = scl_pull; dp = sda_pull; bz = busy; moved = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (scl_pull != sp || sda_pull != dp || busy != bz) moved = 1'b1;
      end
      chk(!moved, "R11 frozen without tick", moved, 0);
      @(posedge clk); tick_en = 1'b1;
      finish_byte("R11 byte resumes");
    end
    do_stop();

    for (int it = 0; it < 14; it++) begin
      run_byte($urandom_range(0, 7), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0) do_stop();
    end
    if (!stop_det) do_stop();

    // R1: reset in the middle of a byte
    launch(3, 1'b1);
    repeat (40) @(negedge clk);
    len_skip = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy && !stop_det && !irq, "R1 mid-byte reset",
        {scl_pull, sda_pull, busy, stop_det}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(!busy && scl_line && sda_line, "R1 bus free after reset", busy, 0);
    run_byte(6, 1'b1);
    do_stop();

    summary();
    $finish;
  end
endmodule